// File: doc/BRIEF.md
# Odd-Even Transposition Sorting Engine

This block takes a snapshot of N unsigned capacitor voltages and sorts it into ascending order. Each voltage carries the number of the submodule it came from, and that number travels with it. The sort uses alternating compare phases. Phases with an even number compare the pairs (0,1), (2,3), and so on. Phases with an odd number compare the pairs (1,2), (3,4), and so on. Every pair in a phase is compared in parallel. After N phases any input order is fully sorted.

The work follows three stages. In the read stage the loaded array is copied into a working register. In the compare stage, one phase of compare-and-swap is applied on every clock, and the result feeds straight into the next phase. In the write stage the finished order goes back to the result store. A sort therefore takes N+2 clocks from the accepted start to the done pulse. The sorted submodule numbers, and the matching voltages, are then presented as flat buses.

A controller pulses `start` with the voltages on `load_vals`. It watches `busy` and takes the order when `done` pulses. It may then start a second sort in that same cycle.

The engine is a four-state machine. Its state-to-state moves are listed here:
- IDLE→READ: `start` is accepted and the voltages are captured.
- READ→COMPARE: the working copy is made and the phase count is cleared.
- COMPARE→COMPARE: a phase is applied while the phase count is below N-1.
- COMPARE→WRITE: after phase N-1.
- WRITE→IDLE: the result store is written and `done` fires.

Top module: `oets_sorter`

## Requirements
- R1: During and after reset, with no start, `busy` and `done` are 0.
- R2: A `start` seen in IDLE captures `load_vals` and numbers entry i (bits i*VW upward) as submodule i. `busy` is 1 from the next cycle on.
- R3: When `done` is 1, `sorted_val` slot k (bits k*VW upward) is non-decreasing in k, even for a fully reversed input.
- R4: Equal voltages leave in increasing submodule order.
- R5: `sorted_idx` slot k (bits k*IW upward) names the submodule whose loaded voltage sits in `sorted_val` slot k.
- R6: `done` is a one-cycle pulse, N+2 clocks after the edge that accepted `start`. `busy` is 1 for exactly those N+2 cycles before it and 0 when `done` is 1.
- R7: A `start` while `busy` is 1 has no effect. The result and the timing are those of the running sort.
- R8: A `start` in the cycle where `done` is 1 is accepted and begins a new sort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, taken only when idle |
| load_vals | input | N*VW | Voltages, entry i in bits i*VW upward |
| busy | output | 1 | Sort in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| sorted_val | output | N*VW | Sorted voltages, slot 0 is the smallest |
| sorted_idx | output | N*IW | Submodule number for each sorted slot |

## Verification
The reversed input needs every one of the N phases, so an engine that stops one phase early, or starts on the wrong parity, leaves two entries swapped. Inputs that are all equal, and inputs that mix duplicates, show whether the compare swaps on equality. A swap on equality would break the submodule order among equal voltages. A second start injected mid-sort would, in a careless engine, reload the data and return the wrong order late. A start placed exactly in the done cycle would be dropped by an engine that only listens after going fully idle.

// File: rtl/oets_pkg.sv
package oets_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ    = 2'd1,
        ST_COMPARE = 2'd2,
        ST_WRITE   = 2'd3
    } oets_state_e;
endpackage

// File: rtl/oets_cas.sv
module oets_cas #(
    parameter int VW = 12,
    parameter int IW = 3
) (
    input  logic [VW-1:0] a_v,
    input  logic [IW-1:0] a_i,
    input  logic [VW-1:0] b_v,
    input  logic [IW-1:0] b_i,
    output logic [VW-1:0] lo_v,
    output logic [IW-1:0] lo_i,
    output logic [VW-1:0] hi_v,
    output logic [IW-1:0] hi_i
);
    // strict compare: equal keys never move, keeping the sort stable
    logic swap;
    assign swap = a_v > b_v;
    assign lo_v = swap ? b_v : a_v;
    assign lo_i = swap ? b_i : a_i;
    assign hi_v = swap ? a_v : b_v;
    assign hi_i = swap ? a_i : b_i;
endmodule

// File: rtl/oets_phase.sv
module oets_phase #(
    parameter int N  = 8,
    parameter int VW = 12,
    parameter int IW = 3
) (
    input  logic          odd,
    input  logic [N*VW-1:0] in_v,
    input  logic [N*IW-1:0] in_i,
    output logic [N*VW-1:0] out_v,
    output logic [N*IW-1:0] out_i
);
    logic [VW-1:0] c_lo_v [N-1];
    logic [IW-1:0] c_lo_i [N-1];
    logic [VW-1:0] c_hi_v [N-1];
    logic [IW-1:0] c_hi_i [N-1];

    // one comparator per adjacent pair; the phase parity picks which are used
    for (genvar j = 0; j < N-1; j++) begin : g_pair
        oets_cas #(.VW(VW), .IW(IW)) u_cas (
            .a_v (in_v[j*VW +: VW]),
            .a_i (in_i[j*IW +: IW]),
            .b_v (in_v[(j+1)*VW +: VW]),
            .b_i (in_i[(j+1)*IW +: IW]),
            .lo_v(c_lo_v[j]),
            .lo_i(c_lo_i[j]),
            .hi_v(c_hi_v[j]),
            .hi_i(c_hi_i[j])
        );
    end

    for (genvar p = 0; p < N; p++) begin : g_pos
        if (p == 0) begin : g_first
            assign out_v[p*VW +: VW] = !odd ? c_lo_v[0] : in_v[p*VW +: VW];
            assign out_i[p*IW +: IW] = !odd ? c_lo_i[0] : in_i[p*IW +: IW];
        end else if (p == N-1) begin : g_last
            assign out_v[p*VW +: VW] = (odd == 1'((p-1) % 2)) ? c_hi_v[p-1] : in_v[p*VW +: VW];
            assign out_i[p*IW +: IW] = (odd == 1'((p-1) % 2)) ? c_hi_i[p-1] : in_i[p*IW +: IW];
        end else begin : g_mid
            assign out_v[p*VW +: VW] = (odd == 1'(p % 2)) ? c_lo_v[p] : c_hi_v[p-1];
            assign out_i[p*IW +: IW] = (odd == 1'(p % 2)) ? c_lo_i[p] : c_hi_i[p-1];
        end
    end
endmodule

// File: rtl/oets_sorter.sv
module oets_sorter
    import oets_pkg::*;
#(
    parameter int N  = 8,
    parameter int VW = 12,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N*VW-1:0] load_vals,
    output logic            busy,
    output logic            done,
    output logic [N*VW-1:0] sorted_val,
    output logic [N*IW-1:0] sorted_idx
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam int LW = $clog2(N + 3);

    oets_state_e st, nxt_st;
    logic [CW-1:0]   ph;
    logic [N*VW-1:0] arr_v, wrk_v, nxt_v;
    logic [N*IW-1:0] arr_i, wrk_i, nxt_i, init_i;

    for (genvar j = 0; j < N; j++) begin : g_init
        assign init_i[j*IW +: IW] = IW'(j);
    end

    oets_phase #(.N(N), .VW(VW), .IW(IW)) u_phase (
        .odd  (ph[0]),
        .in_v (wrk_v),
        .in_i (wrk_i),
        .out_v(nxt_v),
        .out_i(nxt_i)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt_st;
    end

    always_comb begin
        nxt_st = st;
        unique case (st)
            ST_IDLE:    if (start) nxt_st = ST_READ;
            ST_READ:    nxt_st = ST_COMPARE;
            ST_COMPARE: if (ph == CW'(N-1)) nxt_st = ST_WRITE;
            ST_WRITE:   nxt_st = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            ph    <= '0;
            arr_v <= '0;
            arr_i <= '0;
            wrk_v <= '0;
            wrk_i <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    arr_v <= load_vals;
                    arr_i <= init_i;
                end
                ST_READ: begin
                    wrk_v <= arr_v;
                    wrk_i <= arr_i;
                    ph    <= '0;
                end
                ST_COMPARE: begin
                    wrk_v <= nxt_v;
                    wrk_i <= nxt_i;
                    ph    <= ph + 1'b1;
                end
                ST_WRITE: begin
                    arr_v <= wrk_v;
                    arr_i <= wrk_i;
                    done  <= 1'b1;
                end
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign sorted_val = arr_v;
    assign sorted_idx = arr_i;

    // cycle counter used only by the latency check
    logic [LW-1:0] a_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     a_cnt <= '0;
        else if (st == ST_IDLE && start) a_cnt <= '0;
        else if (busy)                  a_cnt <= a_cnt + 1'b1;
    end

    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (a_cnt == LW'(N + 2)) && !busy);
    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(arr_v) || done));

    for (genvar j = 0; j < N-1; j++) begin : g_chk
        a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> sorted_val[j*VW +: VW] <= sorted_val[(j+1)*VW +: VW]);
        a_r4_tie: assert property (@(posedge clk) disable iff (!rst_n)
            (done && sorted_val[j*VW +: VW] == sorted_val[(j+1)*VW +: VW])
            |-> sorted_idx[j*IW +: IW] < sorted_idx[(j+1)*IW +: IW]);
    end
endmodule

// File: tb/test_oets_sorter.sv
module test_oets_sorter;
    localparam int N  = 8;
    localparam int VW = 12;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N*VW-1:0] load_vals = '0;
    logic            busy, done;
    logic [N*VW-1:0] sorted_val;
    logic [N*IW-1:0] sorted_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    oets_sorter #(.N(N), .VW(VW)) i_oets_sorter (
        .clk(clk), .rst_n(rst_n), .start(start), .load_vals(load_vals),
        .busy(busy), .done(done), .sorted_val(sorted_val), .sorted_idx(sorted_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference: stable insertion sort of (voltage, submodule)
    task automatic check_sorted(input logic [N*VW-1:0] v, input string req);
        int ev[N];
        int ei[N];
        for (int i = 0; i < N; i++) begin
            ev[i] = int'(v[i*VW +: VW]);
            ei[i] = i;
        end
        for (int i = 1; i < N; i++) begin
            for (int j = i; j > 0 && ev[j-1] > ev[j]; j--) begin
                int tv, ti;
                tv = ev[j]; ev[j] = ev[j-1]; ev[j-1] = tv;
                ti = ei[j]; ei[j] = ei[j-1]; ei[j-1] = ti;
            end
        end
        for (int k = 0; k < N; k++) begin
            chk(int'(sorted_idx[k*IW +: IW]) == ei[k], {req, " idx"},
                int'(sorted_idx[k*IW +: IW]), ei[k]);
            chk(int'(sorted_val[k*VW +: VW]) == ev[k], {req, " val"},
                int'(sorted_val[k*VW +: VW]), ev[k]);
        end
    endtask

    // caller stands at a negedge
    task automatic launch(input logic [N*VW-1:0] v);
        load_vals = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    endtask

    task automatic wait_done(output int lat, input int inj_at, input logic [N*VW-1:0] inj_v);
        lat = 0;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
            if (lat == inj_at) begin
                load_vals = inj_v;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (lat >= 1000) chk(1'b0, "watchdog", lat, N + 2);
    endtask

    task automatic run_one(input logic [N*VW-1:0] v, input string req);
        int lat;
        launch(v);
        wait_done(lat, 0, '0);
        chk(lat == N + 2, "R6 latency", lat, N + 2);
        chk(busy == 1'b0, "R6 busy low at done", int'(busy), 0);
        check_sorted(v, req);
        @(negedge clk);
        chk(done == 1'b0, "R6 single pulse", int'(done), 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy idle", int'(busy), 0);
        chk(done == 1'b0, "R1 done idle", int'(done), 0);
    endtask

    task automatic t_reverse();
        logic [N*VW-1:0] v;
        for (int i = 0; i < N; i++) v[i*VW +: VW] = VW'((N - i) * 100);
        run_one(v, "R3 reversed");
    endtask

    task automatic t_sorted();
        logic [N*VW-1:0] v;
        for (int i = 0; i < N; i++) v[i*VW +: VW] = VW'(i * 7 + 3);
        run_one(v, "R3 presorted");
    endtask

    task automatic t_scatter();
        logic [N*VW-1:0] v;
        int s = 12345;
        for (int i = 0; i < N; i++) begin
            s = (s * 1103 + 4321) % 65521;
            v[i*VW +: VW] = VW'(s);
        end
        run_one(v, "R5 scattered");
    endtask

    task automatic t_all_equal();
        logic [N*VW-1:0] v;
        for (int i = 0; i < N; i++) v[i*VW +: VW] = VW'(2300);
        run_one(v, "R4 all equal");
    endtask

    task automatic t_dups();
        logic [N*VW-1:0] v;
        for (int i = 0; i < N; i++) v[i*VW +: VW] = VW'(((N - i) % 3) * 50 + 10);
        run_one(v, "R4 duplicates");
    endtask

    task automatic t_start_busy();
        logic [N*VW-1:0] v1, v2;
        int lat;
        for (int i = 0; i < N; i++) begin
            v1[i*VW +: VW] = VW'((i * 5) % N + 40);
            v2[i*VW +: VW] = VW'(4000 - i);
        end
        launch(v1);
        wait_done(lat, 3, v2);
        chk(lat == N + 2, "R7 latency unchanged", lat, N + 2);
        check_sorted(v1, "R7 result of first sort");
        @(negedge clk);
        chk(busy == 1'b0, "R7 no extra sort", int'(busy), 0);
    endtask

    task automatic t_restart();
        logic [N*VW-1:0] v1, v2;
        int lat;
        for (int i = 0; i < N; i++) begin
            v1[i*VW +: VW] = VW'(i * 300 + 1);
            v2[i*VW +: VW] = VW'(((i * 3) % N) * 11);
        end
        launch(v1);
        wait_done(lat, 0, '0);
        check_sorted(v1, "R8 first");
        launch(v2);
        wait_done(lat, 0, '0);
        chk(lat == N + 2, "R8 restart latency", lat, N + 2);
        check_sorted(v2, "R8 second");
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_reverse();
        t_sorted();
        t_scatter();
        t_all_equal();
        t_dups();
        t_start_busy();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule